// File: doc/BRIEF.md
# Coprocessor Transfer Limit Guard

This block sits on the operand path between a CPU and its numeric coprocessor. Every memory operand transfer the coprocessor asks for is tested against the limit of the segment in use. A transfer that stays inside the limit gets a one-cycle grant. A transfer that runs past the limit is never granted. Instead, the block raises a segment-overrun interrupt request, which belongs to vector 9. That request is asynchronous to the instruction the CPU is executing, and it carries no note of which coprocessor operation caused it.

While the overrun is pending, the block refuses every coprocessor wait or escape command except the init command. A refused command gets a reject pulse and never stalls. Because of this, the CPU cannot end up waiting for an idle coprocessor while the coprocessor waits for the CPU to service its data request. The condition ends through an explicit clear strobe, a coprocessor reset, or an accepted init command.

The block keeps two registers: the address of the last escape instruction that was accepted, and the address of the last operand examined. Fault handling software reads them through a small register read port, as a store-environment read would, once the interrupt has been cleared.

Top module: `xfer_limit_guard`

## Requirements
- R1: After a synchronous active-low reset, ovr_irq, xfer_grant, cmd_accept and cmd_reject are 0, and both saved address registers read 0.
- R2: When no overrun is pending, a transfer request whose last byte (xfer_offset + xfer_len_m1, computed one bit wider than the address) is at or below seg_limit produces xfer_grant high for exactly the next cycle.
- R3: When no overrun is pending, a transfer request whose last byte is above seg_limit gets no grant, and ovr_irq is high from the next cycle. This includes a transfer that wraps past the top of the address space.
- R4: Once high, ovr_irq stays high until a cycle with irq_clear, cop_reset or a valid init command. It is low in the cycle after such a strobe, and also after irq_clear and cop_reset arrive together.
- R5: While ovr_irq is high, a valid command of class wait (cmd_class 1) or escape (cmd_class 2) gives cmd_reject high for exactly the next cycle and no accept. The command never stalls.
- R6: A valid init command (cmd_class 3) is always followed by cmd_accept in the next cycle, and it clears a pending overrun.
- R7: A valid command is accepted in the next cycle whenever no overrun is pending. A valid non-coprocessor command (cmd_class 0) is accepted even while an overrun is pending.
- R8: With no overrun pending, each transfer request stores its xfer_offset as the operand address, including the request that faults. Each accepted escape command stores cmd_addr as the instruction address. rd_sel 0 reads the operand address and rd_sel 1 reads the instruction address, combinationally.
- R9: While an overrun is pending, transfer requests are neither granted nor stored, and both saved addresses stay frozen. They remain readable after the condition clears.
- R10: When no overrun is pending, a faulting transfer in the same cycle as a clear strobe or init command still raises ovr_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_req | input | 1 | Operand transfer request for one cycle |
| xfer_offset | input | ADDR_W | Offset of the first operand byte |
| xfer_len_m1 | input | LEN_W | Operand length in bytes minus one |
| seg_limit | input | ADDR_W | Highest valid offset of the segment |
| cmd_valid | input | 1 | Command strobe |
| cmd_class | input | 2 | 0 other, 1 wait, 2 escape, 3 init |
| cmd_addr | input | ADDR_W | Instruction address of the command |
| irq_clear | input | 1 | Clears a pending overrun |
| cop_reset | input | 1 | Coprocessor reset, clears a pending overrun |
| rd_sel | input | 1 | Read select: 0 operand address, 1 instruction address |
| xfer_grant | output | 1 | One-cycle grant of an in-limit transfer |
| ovr_irq | output | 1 | Overrun interrupt request, also the command lockout |
| cmd_accept | output | 1 | One-cycle command accept |
| cmd_reject | output | 1 | One-cycle command reject |
| rd_data | output | ADDR_W | Selected saved address |

## Verification
The bench builds the guard with an 8-bit address and a 3-bit length field. With these widths, offsets near 0xFF can be pushed past the top of the address space, and a limit of 0xFF still catches the wrapped sum through the carry bit. Short operands also land a last byte exactly on the limit, or one byte past it, often enough during random traffic. Random commands, clears and resets overlap faulting transfers in the same cycle, which exercises the precedence of a new fault over a clear.

// File: rtl/xlg_pkg.sv
`timescale 1ns/1ps
package xlg_pkg;
   typedef enum logic [1:0] {
      CMD_OTHER = 2'd0,
      CMD_WAIT  = 2'd1,
      CMD_ESC   = 2'd2,
      CMD_INIT  = 2'd3
   } cmd_class_e;

   localparam int unsigned SLOT_OPND = 0;
   localparam int unsigned SLOT_INSN = 1;
   localparam int unsigned NUM_SLOTS = 2;
endpackage

// File: rtl/xlg_range_chk.sv
`timescale 1ns/1ps
module xlg_range_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned LEN_W  = 7
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [ADDR_W-1:0] limit,
   output logic              beyond
);
   localparam int unsigned SUM_W = ADDR_W + 1;
   localparam int unsigned PAD_W = SUM_W - LEN_W;

   logic [SUM_W-1:0] last_byte;

   // one extra bit keeps a sum that wraps the address space above any limit
   always_comb begin
      last_byte = {1'b0, offset} + {{PAD_W{1'b0}}, len_m1};
      beyond    = last_byte > {1'b0, limit};
   end
endmodule

// File: rtl/xlg_cmd_gate.sv
`timescale 1ns/1ps
module xlg_cmd_gate
   import xlg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_class,
   input  logic       locked,
   output logic       init_seen,
   output logic       esc_take,
   output logic       accept_q,
   output logic       reject_q
);
   cmd_class_e cls;
   logic       gated_cls;
   logic       refuse;

   always_comb begin
      cls       = cmd_class_e'(cmd_class);
      gated_cls = (cls == CMD_WAIT) || (cls == CMD_ESC);
      refuse    = cmd_valid && locked && gated_cls;
      init_seen = cmd_valid && (cls == CMD_INIT);
      esc_take  = cmd_valid && (cls == CMD_ESC) && !locked;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accept_q <= 1'b0;
         reject_q <= 1'b0;
      end else begin
         accept_q <= cmd_valid && !refuse;
         reject_q <= refuse;
      end
   end
endmodule

// File: rtl/xlg_fault_ctl.sv
`timescale 1ns/1ps
module xlg_fault_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_req,
   input  logic beyond,
   input  logic clr_strobe,
   input  logic rst_strobe,
   input  logic init_seen,
   output logic fault_q,
   output logic grant_q
);
   logic clearing;
   logic new_fault;

   always_comb begin
      clearing  = clr_strobe || rst_strobe || init_seen;
      new_fault = xfer_req && beyond;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         grant_q <= 1'b0;
      end else begin
         grant_q <= xfer_req && !beyond && !fault_q;
         if (fault_q)
            fault_q <= !clearing;
         else
            fault_q <= new_fault;
      end
   end
endmodule

// File: rtl/xlg_addr_bank.sv
`timescale 1ns/1ps
module xlg_addr_bank #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned NREG   = 2,
   localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NREG-1:0]             cap_en,
   input  logic [NREG-1:0][ADDR_W-1:0] cap_val,
   input  logic [SEL_W-1:0]            rd_sel,
   output logic [NREG-1:0][ADDR_W-1:0] regs_q,
   output logic [ADDR_W-1:0]           rd_data
);
   for (genvar g = 0; g < NREG; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[g] <= '0;
         else if (cap_en[g])
            regs_q[g] <= cap_val[g];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_sel == SEL_W'(i))
            rd_data = regs_q[i];
   end
endmodule

// File: rtl/xfer_limit_guard.sv
`timescale 1ns/1ps
module xfer_limit_guard
   import xlg_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_req,
   input  logic [ADDR_W-1:0] xfer_offset,
   input  logic [LEN_W-1:0]  xfer_len_m1,
   input  logic [ADDR_W-1:0] seg_limit,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_class,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              irq_clear,
   input  logic              cop_reset,
   input  logic              rd_sel,
   output logic              xfer_grant,
   output logic              ovr_irq,
   output logic              cmd_accept,
   output logic              cmd_reject,
   output logic [ADDR_W-1:0] rd_data
);
   if (LEN_W < 1 || LEN_W > ADDR_W) begin : g_bad_len
      $error("xfer_limit_guard: LEN_W must be in 1..ADDR_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("xfer_limit_guard: ADDR_W must be at least 2");
   end

   logic                           beyond;
   logic                           fault_q;
   logic                           init_seen;
   logic                           esc_take;
   logic [NUM_SLOTS-1:0]           cap_en;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] cap_val;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] bank_q;

   xlg_range_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_range (
      .offset (xfer_offset),
      .len_m1 (xfer_len_m1),
      .limit  (seg_limit),
      .beyond (beyond)
   );

   xlg_cmd_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_class (cmd_class),
      .locked    (fault_q),
      .init_seen (init_seen),
      .esc_take  (esc_take),
      .accept_q  (cmd_accept),
      .reject_q  (cmd_reject)
   );

   xlg_fault_ctl u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_req   (xfer_req),
      .beyond     (beyond),
      .clr_strobe (irq_clear),
      .rst_strobe (cop_reset),
      .init_seen  (init_seen),
      .fault_q    (fault_q),
      .grant_q    (xfer_grant)
   );

   always_comb begin
      cap_en                = '0;
      cap_en[SLOT_OPND]     = xfer_req && !fault_q;
      cap_en[SLOT_INSN]     = esc_take;
      cap_val               = '0;
      cap_val[SLOT_OPND]    = xfer_offset;
      cap_val[SLOT_INSN]    = cmd_addr;
   end

   xlg_addr_bank #(.ADDR_W(ADDR_W), .NREG(NUM_SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .cap_val (cap_val),
      .rd_sel  (rd_sel),
      .regs_q  (bank_q),
      .rd_data (rd_data)
   );

   assign ovr_irq = fault_q;
endmodule

// File: rtl/xlg_guard_chk.sv
`timescale 1ns/1ps
module xlg_guard_chk #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_req,
   input logic              cmd_valid,
   input logic [1:0]        cmd_class,
   input logic              irq_clear,
   input logic              cop_reset,
   input logic              xfer_grant,
   input logic              ovr_irq,
   input logic              cmd_accept,
   input logic              cmd_reject,
   input logic [ADDR_W-1:0] opnd_q,
   input logic [ADDR_W-1:0] insn_q
);
   // R2
   grant_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_grant |-> ($past(xfer_req) && !$past(ovr_irq)));

   // R3
   fault_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_irq) |-> !xfer_grant);

   // R4
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_irq && !irq_clear && !cop_reset && !(cmd_valid && cmd_class == 2'd3))
      |=> ovr_irq);

   // R4
   dual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_irq && irq_clear && cop_reset) |=> !ovr_irq);

   // R5
   reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> ($past(ovr_irq) && $past(cmd_valid) &&
                      ($past(cmd_class) == 2'd1 || $past(cmd_class) == 2'd2)));

   // R5
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_accept && cmd_reject));

   // R6
   init_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_class == 2'd3) |=> cmd_accept);

   // R9
   opnd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_irq |=> $stable(opnd_q));

   // R9
   insn_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_irq |=> $stable(insn_q));
endmodule

bind xfer_limit_guard xlg_guard_chk #(.ADDR_W(ADDR_W)) u_guard_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_req   (xfer_req),
   .cmd_valid  (cmd_valid),
   .cmd_class  (cmd_class),
   .irq_clear  (irq_clear),
   .cop_reset  (cop_reset),
   .xfer_grant (xfer_grant),
   .ovr_irq    (ovr_irq),
   .cmd_accept (cmd_accept),
   .cmd_reject (cmd_reject),
   .opnd_q     (bank_q[0]),
   .insn_q     (bank_q[1])
);

// File: tb/test_xfer_limit_guard.sv
`timescale 1ns/1ps
module test_xfer_limit_guard;
   localparam int AW = 8;
   localparam int LW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xfer_req = 1'b0;
   logic [AW-1:0] xfer_offset = '0;
   logic [LW-1:0] xfer_len_m1 = '0;
   logic [AW-1:0] seg_limit = '0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_class = 2'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic          irq_clear = 1'b0;
   logic          cop_reset = 1'b0;
   logic          rd_sel = 1'b0;
   logic          xfer_grant, ovr_irq, cmd_accept, cmd_reject;
   logic [AW-1:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference model state
   bit          m_fault, m_grant, m_acc, m_rej;
   int          m_opnd, m_insn;

   always #4 clk = ~clk;

   xfer_limit_guard #(.ADDR_W(AW), .LEN_W(LW)) i_xfer_limit_guard (
      .clk, .rst_n, .xfer_req, .xfer_offset, .xfer_len_m1, .seg_limit,
      .cmd_valid, .cmd_class, .cmd_addr, .irq_clear, .cop_reset, .rd_sel,
      .xfer_grant, .ovr_irq, .cmd_accept, .cmd_reject, .rd_data
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int  last;
      bit  bad, clr, lock;
      if (!rst_n) begin
         m_fault <= 0; m_grant <= 0; m_acc <= 0; m_rej <= 0;
         m_opnd  <= 0; m_insn  <= 0;
      end else begin
         last = int'(xfer_offset) + int'(xfer_len_m1);
         bad  = xfer_req && (last > int'(seg_limit));
         clr  = irq_clear || cop_reset || (cmd_valid && cmd_class == 2'd3);
         lock = cmd_valid && m_fault && (cmd_class == 2'd1 || cmd_class == 2'd2);
         m_grant <= xfer_req && !bad && !m_fault;
         m_fault <= m_fault ? !clr : bad;
         m_acc   <= cmd_valid && !lock;
         m_rej   <= lock;
         if (xfer_req && !m_fault) m_opnd <= int'(xfer_offset);
         if (cmd_valid && cmd_class == 2'd2 && !m_fault) m_insn <= int'(cmd_addr);
      end
   end

   // compare every cycle, 3 ns after the edge
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         chk("R2 xfer_grant", int'(xfer_grant), int'(m_grant));
         chk("R3/R4/R10 ovr_irq", int'(ovr_irq), int'(m_fault));
         chk("R6/R7 cmd_accept", int'(cmd_accept), int'(m_acc));
         chk("R5 cmd_reject", int'(cmd_reject), int'(m_rej));
         chk("R8/R9 rd_data", int'(rd_data), rd_sel ? m_insn : m_opnd);
      end
   end

   task automatic nxt();
      @(negedge clk);
      xfer_req = 0; cmd_valid = 0; irq_clear = 0; cop_reset = 0;
   endtask

   task automatic xfer(input int off, input int len, input int lim);
      nxt();
      xfer_req = 1; xfer_offset = AW'(off); xfer_len_m1 = LW'(len); seg_limit = AW'(lim);
   endtask

   task automatic cmd(input int cls, input int addr);
      nxt();
      cmd_valid = 1; cmd_class = 2'(cls); cmd_addr = AW'(addr);
   endtask

   task automatic expect_now(input string tag, input int act, input int exp);
      @(posedge clk); #3;
      chk(tag, act, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      chk("R1 ovr_irq", int'(ovr_irq), 0);
      chk("R1 xfer_grant", int'(xfer_grant), 0);
      chk("R1 cmd_accept", int'(cmd_accept), 0);
      chk("R1 cmd_reject", int'(cmd_reject), 0);
      chk("R1 rd_data opnd", int'(rd_data), 0);
      rd_sel = 1; #1;
      chk("R1 rd_data insn", int'(rd_data), 0);
      rst_n = 1;
      // R2: in-limit and exact boundary
      xfer('h10, 3, 'h40);
      xfer('h3D, 3, 'h40);
      cmd(2, 'hA5);
      // R3: one byte past the limit
      xfer('h3E, 3, 'h40);
      nxt(); rd_sel = 0;
      // R5/R7/R9 during the fault
      cmd(1, 'h11);
      cmd(2, 'h22);
      xfer('h01, 0, 'h40);
      cmd(0, 'h33);
      nxt(); rd_sel = 1;
      // R4: explicit clear, then addresses still readable
      nxt(); irq_clear = 1;
      nxt(); rd_sel = 0;
      nxt();
      // R6: fault then init
      xfer('h80, 1, 'h7F);
      cmd(3, 'h44);
      // R3: wrap past the address top with limit FF
      xfer('hFE, 7, 'hFF);
      // R4: clear and reset together
      nxt(); irq_clear = 1; cop_reset = 1;
      // R10: faulting transfer with clear in the same cycle
      xfer('h20, 7, 'h21);
      irq_clear = 1;
      nxt(); cop_reset = 1;
      xfer('h20, 0, 'h20);
      nxt();
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         nxt();
         xfer_req    = ($urandom_range(0, 2) == 0);
         seg_limit   = ($urandom_range(0, 3) == 0) ? AW'(8'hFF) : AW'($urandom);
         xfer_offset = ($urandom_range(0, 3) == 0) ? seg_limit - AW'($urandom_range(0, 7))
                                                   : AW'($urandom);
         xfer_len_m1 = LW'($urandom);
         cmd_valid   = $urandom_range(0, 1) == 1;
         cmd_class   = 2'($urandom);
         cmd_addr    = AW'($urandom);
         irq_clear   = ($urandom_range(0, 7) == 0);
         cop_reset   = ($urandom_range(0, 15) == 0);
         rd_sel      = $urandom_range(0, 1) == 1;
      end
      nxt();
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R5 run did not complete actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule